// File: doc/BRIEF.md
# Pointer-Addressed SMBus Slave

This block is the slave side of a two-wire management bus. It gives a host access to a byte-wide register file through an internal pointer. The SCL and SDA pins are brought into the system clock domain through a flop chain. START and STOP conditions are recognised from the synchronized levels, and the incoming 7-bit device address is compared with the block's own address. The five upper bits of that address are a parameter. The two lower bits come from a three-level strap that is captured while reset is held.

A write transaction always carries the pointer value in its first data byte. An optional second byte is stored at the register the pointer selects, and any byte after that is refused. A read transaction returns one byte from the register the pointer currently selects, so a pointer-only write followed by a read fetches any register. The block only ever pulls SDA low, through an open-drain enable. The register file itself lives outside the block. A one-cycle read strobe and a one-cycle write strobe let that file attach side effects to accesses.

Top module: `smbus_regptr_slave`

## Requirements
- R1: The device address is the parameter `ADDR_UPPER` (default 01011) followed by two strap-derived bits. For `strap_sel` = 2'b00 (tied low) the two bits are 10. For 2'b10 (tied high) they are 01. For 2'b01 (open) and 2'b11 they are 00.
- R2: `strap_sel` is captured only while `rst_n` is low. Changing it after reset leaves the address unchanged.
- R3: After a START, the block shifts in 8 bits MSB first on SCL rising edges: 7 address bits, then R/W (1 = read). On a match it holds `sda_oe` high through the 9th clock. On a mismatch it leaves `sda_oe` low until the next START.
- R4: The first data byte of a write is acknowledged and becomes the pointer, which is presented on `reg_addr`.
- R5: A second write data byte is acknowledged. It produces exactly one `reg_we` cycle, with `reg_addr` equal to the pointer and `reg_wdata` equal to the byte.
- R6: When a read address is acknowledged, `reg_re` pulses for one cycle and `reg_rdata` for the pointer is captured. A read after a pointer-only write returns the register that pointer selects.
- R7: The read byte is sent MSB first and SDA is released after its 8th bit. The block then does not drive SDA until the next START, whatever the master does, and a read never causes a write.
- R8: Data bytes after the second one in a write are not acknowledged and not stored.
- R9: A START or STOP in the middle of a byte abandons the transaction. No write occurs and the pointer keeps its value. A START then begins a new address phase.
- R10: During and right after reset, `sda_oe`, `reg_we` and `reg_re` are 0 and `reg_addr` is 0x00.
- R11: `sda_oe` changes level only while the synchronized SCL is low.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset; strap capture window |
| scl_in | input | 1 | Bus clock level from the pad |
| sda_in | input | 1 | Bus data level from the pad (wired value) |
| strap_sel | input | 2 | Three-level strap code: 00 low, 01 open, 10 high |
| sda_oe | output | 1 | 1 = pull SDA low |
| reg_addr | output | 8 | Pointer, selects the register |
| reg_wdata | output | 8 | Byte to store |
| reg_we | output | 1 | One-cycle store strobe |
| reg_re | output | 1 | One-cycle read strobe; `reg_rdata` is captured in this cycle |
| reg_rdata | input | 8 | Contents of the register at `reg_addr` |

## Verification
The bench aborts transactions mid-byte with both a repeated START and a STOP. A design that committed partial bytes would show an unexpected write or a moved pointer. It sends a third write byte, which would be acknowledged and stored by a design that forgets the two-byte limit. It keeps clocking after a read, which exposes a slave that keeps driving stale data. It also changes the strap while out of reset and then resets with every strap code, so an address that follows the live pin or a wrong decode of a strap level shows up as a wrong acknowledge.

// File: rtl/smbus_slv_pkg.sv
// Shared types and helpers for the pointer-addressed bus slave.
// Assumes byte-wide registers and a 7-bit device address.
package smbus_slv_pkg;

    localparam int BYTE_W = 8;
    localparam int CNT_W  = $clog2(BYTE_W + 1);

    localparam logic [1:0] STRAP_TIED_LOW  = 2'b00;
    localparam logic [1:0] STRAP_FLOATING  = 2'b01;
    localparam logic [1:0] STRAP_TIED_HIGH = 2'b10;

    typedef enum logic [2:0] {
        ST_IDLE,
        ST_ADDR,
        ST_ADDR_ACK,
        ST_PTR,
        ST_PTR_ACK,
        ST_WDAT,
        ST_WDAT_ACK,
        ST_SEND
    } slv_state_t;

    // Two low address bits selected by the strap level.
    function automatic logic [1:0] strap_low_bits(input logic [1:0] code);
        logic [1:0] bits;
        case (code)
            STRAP_TIED_LOW:  bits = 2'b10;
            STRAP_TIED_HIGH: bits = 2'b01;
            default:         bits = 2'b00;
        endcase
        return bits;
    endfunction

endpackage

// File: rtl/smb_line_sync.sv
// Brings SCL and SDA into the clock domain and derives bus events.
// Assumes SYNC_STAGES >= 2 and both lines idle high.
// Bit 0 of the internal vectors is SCL, bit 1 is SDA.
module smb_line_sync #(
    parameter int SYNC_STAGES = 2
) (
    input  logic clk,
    input  logic rst_n,
    input  logic scl_in,
    input  logic sda_in,
    output logic scl_s,
    output logic sda_s,
    output logic scl_rise,
    output logic scl_fall,
    output logic start_det,
    output logic stop_det
);
    localparam int N_LINES = 2;

    logic [N_LINES-1:0] raw;
    logic [N_LINES-1:0] cur;
    logic [N_LINES-1:0] prv;

    assign raw = {sda_in, scl_in};

    for (genvar g = 0; g < N_LINES; g++) begin : g_line
        logic [SYNC_STAGES-1:0] pipe;
        logic                   last;

        // Flop chain plus one delayed copy for edge detection.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                pipe <= '1;
                last <= 1'b1;
            end else begin
                pipe <= {pipe[SYNC_STAGES-2:0], raw[g]};
                last <= pipe[SYNC_STAGES-1];
            end
        end

        assign cur[g] = pipe[SYNC_STAGES-1];
        assign prv[g] = last;
    end

    assign scl_s     = cur[0];
    assign sda_s     = cur[1];
    assign scl_rise  = cur[0] & ~prv[0];
    assign scl_fall  = ~cur[0] & prv[0];
    assign start_det = cur[0] & prv[0] & prv[1] & ~cur[1];
    assign stop_det  = cur[0] & prv[0] & ~prv[1] & cur[1];

endmodule

// File: rtl/smb_addr_strap.sv
// Forms the device address from fixed upper bits and a strap that is
// captured only while reset is held.
module smb_addr_strap
    import smbus_slv_pkg::*;
#(
    parameter logic [4:0] ADDR_UPPER = 5'b01011
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic [1:0] strap_sel,
    output logic [6:0] dev_addr
);
    logic [1:0] low_q;

    // Track the strap during reset, freeze it afterwards.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            low_q <= strap_low_bits(strap_sel);
        end
    end

    assign dev_addr = {ADDR_UPPER, low_q};

endmodule

// File: rtl/smb_slave_fsm.sv
// Byte framing, acknowledge and register-pointer logic of the slave.
// Assumes synchronized bus events.
// The master changes SDA only while SCL is low.
module smb_slave_fsm
    import smbus_slv_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              sda_s,
    input  logic              scl_rise,
    input  logic              scl_fall,
    input  logic              start_det,
    input  logic              stop_det,
    input  logic [6:0]        dev_addr,
    input  logic [BYTE_W-1:0] rd_byte,
    output logic              oe,
    output logic [BYTE_W-1:0] ptr,
    output logic [BYTE_W-1:0] wr_byte,
    output logic              wr_pulse,
    output logic              rd_pulse,
    output logic              idle
);
    slv_state_t        st;
    logic [CNT_W-1:0]  bit_cnt;
    logic [BYTE_W-1:0] rx_sh;
    logic [BYTE_W-1:0] tx_sh;
    logic [BYTE_W-1:0] ptr_q;
    logic [BYTE_W-1:0] wdat_q;
    logic              oe_q;
    logic              we_q;
    logic              rd_mode;
    logic              byte_full;
    logic              addr_hit;
    logic              rx_phase;

    assign byte_full = (bit_cnt == CNT_W'(BYTE_W));
    assign addr_hit  = (rx_sh[BYTE_W-1:1] == dev_addr);
    assign rx_phase  = (st == ST_ADDR) || (st == ST_PTR) || (st == ST_WDAT);

    // Read strobe: address byte complete, matched, read direction.
    assign rd_pulse = (st == ST_ADDR) && scl_fall && byte_full
                      && addr_hit && rx_sh[0];

    // Main sequencer: framing, acknowledge and data transfer.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            st      <= ST_IDLE;
            bit_cnt <= '0;
            rx_sh   <= '0;
            tx_sh   <= '0;
            ptr_q   <= '0;
            wdat_q  <= '0;
            oe_q    <= 1'b0;
            we_q    <= 1'b0;
            rd_mode <= 1'b0;
        end else begin
            we_q <= 1'b0;
            if (start_det) begin
                st      <= ST_ADDR;
                bit_cnt <= '0;
                oe_q    <= 1'b0;
            end else if (stop_det) begin
                st      <= ST_IDLE;
                bit_cnt <= '0;
                oe_q    <= 1'b0;
            end else if (rx_phase) begin
                if (scl_rise && !byte_full) begin
                    rx_sh   <= {rx_sh[BYTE_W-2:0], sda_s};
                    bit_cnt <= bit_cnt + 1'b1;
                end else if (scl_fall && byte_full) begin
                    bit_cnt <= '0;
                    if (st == ST_ADDR) begin
                        if (addr_hit) begin
                            oe_q    <= 1'b1;
                            rd_mode <= rx_sh[0];
                            st      <= ST_ADDR_ACK;
                            if (rx_sh[0]) begin
                                tx_sh <= rd_byte;
                            end
                        end else begin
                            st <= ST_IDLE;
                        end
                    end else if (st == ST_PTR) begin
                        ptr_q <= rx_sh;
                        oe_q  <= 1'b1;
                        st    <= ST_PTR_ACK;
                    end else begin
                        wdat_q <= rx_sh;
                        we_q   <= 1'b1;
                        oe_q   <= 1'b1;
                        st     <= ST_WDAT_ACK;
                    end
                end
            end else begin
                case (st)
                    ST_ADDR_ACK: begin
                        if (scl_fall) begin
                            bit_cnt <= '0;
                            if (rd_mode) begin
                                oe_q <= ~tx_sh[BYTE_W-1];
                                st   <= ST_SEND;
                            end else begin
                                oe_q <= 1'b0;
                                st   <= ST_PTR;
                            end
                        end
                    end
                    ST_PTR_ACK: begin
                        if (scl_fall) begin
                            oe_q <= 1'b0;
                            st   <= ST_WDAT;
                        end
                    end
                    ST_WDAT_ACK: begin
                        if (scl_fall) begin
                            oe_q <= 1'b0;
                            st   <= ST_IDLE;
                        end
                    end
                    ST_SEND: begin
                        if (scl_rise) begin
                            bit_cnt <= bit_cnt + 1'b1;
                        end else if (scl_fall) begin
                            if (byte_full) begin
                                oe_q <= 1'b0;
                                st   <= ST_IDLE;
                            end else begin
                                tx_sh <= {tx_sh[BYTE_W-2:0], 1'b0};
                                oe_q  <= ~tx_sh[BYTE_W-2];
                            end
                        end
                    end
                    default: begin
                    end
                endcase
            end
        end
    end

    assign oe       = oe_q;
    assign ptr      = ptr_q;
    assign wr_byte  = wdat_q;
    assign wr_pulse = we_q;
    assign idle     = (st == ST_IDLE);

endmodule

// File: rtl/smbus_regptr_slave.sv
// Top of the pointer-addressed bus slave. It joins the line synchronizer,
// the strap-derived address and the transaction sequencer.
// Assumes an external pad that turns sda_oe into an open-drain pull-down.
// The register file is external and answers reg_rdata combinationally.
module smbus_regptr_slave
    import smbus_slv_pkg::*;
#(
    parameter logic [4:0] ADDR_UPPER  = 5'b01011,
    parameter int         SYNC_STAGES = 2
) (
    input  logic       clk,
    input  logic       rst_n,
    input  logic       scl_in,
    input  logic       sda_in,
    input  logic [1:0] strap_sel,
    output logic       sda_oe,
    output logic [7:0] reg_addr,
    output logic [7:0] reg_wdata,
    output logic       reg_we,
    output logic       reg_re,
    input  logic [7:0] reg_rdata
);
    logic       scl_sync;
    logic       sda_sync;
    logic       scl_rise;
    logic       scl_fall;
    logic       start_det;
    logic       stop_det;
    logic [6:0] dev_addr;
    logic       fsm_idle;

    smb_line_sync #(
        .SYNC_STAGES(SYNC_STAGES)
    ) u_sync (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_in   (scl_in),
        .sda_in   (sda_in),
        .scl_s    (scl_sync),
        .sda_s    (sda_sync),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det)
    );

    smb_addr_strap #(
        .ADDR_UPPER(ADDR_UPPER)
    ) u_addr (
        .clk      (clk),
        .rst_n    (rst_n),
        .strap_sel(strap_sel),
        .dev_addr (dev_addr)
    );

    smb_slave_fsm u_fsm (
        .clk      (clk),
        .rst_n    (rst_n),
        .sda_s    (sda_sync),
        .scl_rise (scl_rise),
        .scl_fall (scl_fall),
        .start_det(start_det),
        .stop_det (stop_det),
        .dev_addr (dev_addr),
        .rd_byte  (reg_rdata),
        .oe       (sda_oe),
        .ptr      (reg_addr),
        .wr_byte  (reg_wdata),
        .wr_pulse (reg_we),
        .rd_pulse (reg_re),
        .idle     (fsm_idle)
    );

endmodule

// File: rtl/smbus_regptr_slave_chk.sv
// Temporal checks for the bus slave, attached by bind.
module smbus_regptr_slave_chk (
    input logic       clk,
    input logic       rst_n,
    input logic       sda_oe,
    input logic       reg_we,
    input logic       reg_re,
    input logic       scl_s,
    input logic [6:0] dev_addr,
    input logic       fsm_idle
);
    logic armed;

    // Marks cycles at least one clock past the end of reset.
    always_ff @(posedge clk) begin
        if (!rst_n) armed <= 1'b0;
        else        armed <= 1'b1;
    end

    // R5: a stored byte produces a single-cycle strobe
    assert_single_write_R5: assert property (@(posedge clk) disable iff (!rst_n)
        reg_we |=> !reg_we);

    // R6: a read produces a single-cycle strobe
    assert_single_read_R6: assert property (@(posedge clk) disable iff (!rst_n)
        reg_re |=> !reg_re);

    // R11: the pull-down only starts while SCL is low
    assert_drive_on_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $rose(sda_oe) |-> !scl_s);

    // R11: the pull-down only ends while SCL is low
    assert_release_on_low_R11: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(sda_oe) |-> !scl_s);

    // R2: the address is frozen once reset is over
    assert_strap_frozen_R2: assert property (@(posedge clk) disable iff (!rst_n)
        armed |-> $stable(dev_addr));

    // R3: an idle slave neither drives the bus nor reads the file
    assert_idle_quiet_R3: assert property (@(posedge clk) disable iff (!rst_n)
        fsm_idle |-> (!sda_oe && !reg_re));

endmodule

bind smbus_regptr_slave smbus_regptr_slave_chk u_chk (
    .clk     (clk),
    .rst_n   (rst_n),
    .sda_oe  (sda_oe),
    .reg_we  (reg_we),
    .reg_re  (reg_re),
    .scl_s   (scl_sync),
    .dev_addr(dev_addr),
    .fsm_idle(fsm_idle)
);

// File: tb/smbus_regptr_slave_test.sv
module smbus_regptr_slave_test;

    localparam int Q = 10;

    typedef struct packed {
        logic [7:0] a;
        logic [7:0] d;
    } wr_item_t;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       scl = 1'b1;
    logic       m_low = 1'b0;
    logic [1:0] strap = 2'b01;
    logic       sda_oe;
    logic [7:0] reg_addr;
    logic [7:0] reg_wdata;
    logic       reg_we;
    logic       reg_re;
    logic [7:0] reg_rdata;
    logic       sda_bus;
    logic [7:0] mem [256];
    logic [7:0] exp_mem [256];

    int checks = 0;
    int errors = 0;
    int re_cnt = 0;
    wr_item_t wq[$];

    always #2 clk = ~clk;

    assign sda_bus   = !(m_low || sda_oe);
    assign reg_rdata = mem[reg_addr];

    smbus_regptr_slave uut (
        .clk      (clk),
        .rst_n    (rst_n),
        .scl_in   (scl),
        .sda_in   (sda_bus),
        .strap_sel(strap),
        .sda_oe   (sda_oe),
        .reg_addr (reg_addr),
        .reg_wdata(reg_wdata),
        .reg_we   (reg_we),
        .reg_re   (reg_re),
        .reg_rdata(reg_rdata)
    );

    function automatic logic [7:0] init_val(input int a);
        return 8'(a) ^ 8'h5A;
    endfunction

    initial begin
        for (int i = 0; i < 256; i++) begin
            mem[i]     = init_val(i);
            exp_mem[i] = init_val(i);
        end
    end

    // Register file model behind the slave.
    always @(posedge clk) begin
        if (reg_we) mem[reg_addr] <= reg_wdata;
    end

    // Scoreboard monitor: every write strobe must match the queue head.
    always @(negedge clk) begin
        if (rst_n && reg_we) begin
            checks++;
            if (wq.size() == 0) begin
                errors++;
                $display("FAIL R5 unexpected write act a=%02h d=%02h exp none",
                         reg_addr, reg_wdata);
            end else begin
                wr_item_t e;
                e = wq.pop_front();
                if (e.a !== reg_addr || e.d !== reg_wdata) begin
                    errors++;
                    $display("FAIL R5 write act a=%02h d=%02h exp a=%02h d=%02h",
                             reg_addr, reg_wdata, e.a, e.d);
                end
            end
        end
        if (rst_n && reg_re) re_cnt++;
    end

    task automatic check(input bit ok, input string req, input string what,
                         input int act, input int exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s %s act=%0h exp=%0h", req, what, act, exp);
        end
    endtask

    task automatic wait_q(input int n);
        repeat (n * Q) @(negedge clk);
    endtask

    task automatic do_reset(input logic [1:0] s);
        strap = s;
        scl   = 1'b1;
        m_low = 1'b0;
        rst_n = 1'b0;
        repeat (6) @(negedge clk);
        rst_n = 1'b1;
        repeat (4) @(negedge clk);
    endtask

    task automatic bus_start();
        m_low = 1'b0;
        wait_q(1);
        scl = 1'b1;
        wait_q(1);
        m_low = 1'b1;
        wait_q(1);
        scl = 1'b0;
        wait_q(1);
    endtask

    task automatic bus_stop();
        m_low = 1'b1;
        wait_q(1);
        scl = 1'b1;
        wait_q(1);
        m_low = 1'b0;
        wait_q(2);
    endtask

    task automatic send_bit(input logic b);
        m_low = !b;
        wait_q(1);
        scl = 1'b1;
        wait_q(2);
        scl = 1'b0;
        wait_q(1);
    endtask

    task automatic get_bit(output logic b, output logic steady);
        logic oe0;
        m_low = 1'b0;
        wait_q(1);
        scl = 1'b1;
        wait_q(1);
        oe0 = sda_oe;
        wait_q(1);
        b = sda_bus;
        steady = (oe0 == sda_oe);
        scl = 1'b0;
        wait_q(1);
    endtask

    task automatic send_byte(input logic [7:0] d, output logic ack);
        logic b;
        logic st;
        for (int i = 7; i >= 0; i--) send_bit(d[i]);
        get_bit(b, st);
        ack = !b;
        check(st, "R11", "sda_oe moved while SCL high", 0, 1);
    endtask

    task automatic send_bits(input logic [7:0] d, input int n);
        for (int i = 7; i > 7 - n; i--) send_bit(d[i]);
    endtask

    task automatic recv_byte(output logic [7:0] d, input logic nack);
        logic b;
        logic st;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b, st);
            d[i] = b;
        end
        send_bit(nack);
    endtask

    task automatic write_ptr(input logic [6:0] a, input logic [7:0] p);
        logic ack;
        bus_start();
        send_byte({a, 1'b0}, ack);
        check(ack, "R3", "address ack", ack, 1);
        send_byte(p, ack);
        check(ack, "R4", "pointer ack", ack, 1);
        bus_stop();
    endtask

    task automatic read_one(input logic [6:0] a, output logic [7:0] d);
        logic ack;
        bus_start();
        send_byte({a, 1'b1}, ack);
        check(ack, "R6", "read address ack", ack, 1);
        recv_byte(d, 1'b1);
        bus_stop();
    endtask

    task automatic probe_ack(input logic [6:0] a, input logic exp, input string req);
        logic ack;
        bus_start();
        send_byte({a, 1'b0}, ack);
        check(ack == exp, req, "address acknowledge", ack, exp);
        bus_stop();
    endtask

    initial begin : watchdog
        repeat (150000) @(posedge clk);
        errors++;
        $display("FAIL watchdog expired act=hung exp=done");
        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

    initial begin : main
        logic       ack;
        logic       b;
        logic       st;
        logic [7:0] d;
        int         re0;

        // R10: reset state
        rst_n = 1'b0;
        repeat (3) @(negedge clk);
        check(sda_oe == 0 && reg_we == 0 && reg_re == 0, "R10", "outputs in reset",
              {sda_oe, reg_we, reg_re}, 0);
        do_reset(2'b01);
        check(sda_oe == 0 && reg_we == 0 && reg_re == 0, "R10", "outputs after reset",
              {sda_oe, reg_we, reg_re}, 0);
        check(reg_addr == 8'h00, "R10", "pointer after reset", reg_addr, 0);

        // R3 R4 R5: full write to 0x2C
        wq.push_back('{a: 8'h10, d: 8'hA5});
        exp_mem[8'h10] = 8'hA5;
        bus_start();
        send_byte({7'h2C, 1'b0}, ack);
        check(ack, "R3", "matched address ack", ack, 1);
        send_byte(8'h10, ack);
        check(ack, "R4", "pointer byte ack", ack, 1);
        send_byte(8'hA5, ack);
        check(ack, "R5", "data byte ack", ack, 1);
        bus_stop();
        check(reg_addr == 8'h10, "R4", "pointer value", reg_addr, 8'h10);

        // R6: pointer-only write then read of an unwritten register
        write_ptr(7'h2C, 8'h33);
        re0 = re_cnt;
        read_one(7'h2C, d);
        check(d == exp_mem[8'h33], "R6", "read after pointer write", d, exp_mem[8'h33]);
        check(re_cnt == re0 + 1, "R6", "read strobe count", re_cnt - re0, 1);

        // R6 R7: read back the written register, master keeps clocking
        write_ptr(7'h2C, 8'h10);
        bus_start();
        send_byte({7'h2C, 1'b1}, ack);
        recv_byte(d, 1'b0);
        check(d == 8'hA5, "R6", "read of written register", d, 8'hA5);
        d = 8'h00;
        for (int i = 7; i >= 0; i--) begin
            get_bit(b, st);
            d[i] = b;
        end
        check(d == 8'hFF && sda_oe == 0, "R7", "bus released after read byte", d, 8'hFF);
        bus_stop();

        // R3: mismatched address is ignored entirely
        bus_start();
        send_byte({7'h2D, 1'b0}, ack);
        check(!ack, "R3", "mismatched address nack", ack, 0);
        send_byte(8'h77, ack);
        check(!ack, "R3", "byte after mismatch nack", ack, 0);
        bus_stop();
        check(reg_addr == 8'h10, "R3", "pointer untouched by mismatch", reg_addr, 8'h10);

        // R8: third byte of a write refused
        wq.push_back('{a: 8'h40, d: 8'h11});
        exp_mem[8'h40] = 8'h11;
        bus_start();
        send_byte({7'h2C, 1'b0}, ack);
        send_byte(8'h40, ack);
        send_byte(8'h11, ack);
        check(ack, "R8", "second data byte ack", ack, 1);
        send_byte(8'h22, ack);
        check(!ack, "R8", "third data byte nack", ack, 0);
        bus_stop();
        read_one(7'h2C, d);
        check(d == 8'h11, "R8", "stored byte intact", d, 8'h11);
        write_ptr(7'h2C, 8'h41);
        read_one(7'h2C, d);
        check(d == exp_mem[8'h41], "R8", "next register not written", d, exp_mem[8'h41]);

        // R9: repeated START in the middle of a data byte
        bus_start();
        send_byte({7'h2C, 1'b0}, ack);
        send_byte(8'h50, ack);
        send_bits(8'hFF, 4);
        bus_start();
        send_byte({7'h2C, 1'b1}, ack);
        check(ack, "R9", "new address phase after START", ack, 1);
        recv_byte(d, 1'b1);
        bus_stop();
        check(d == exp_mem[8'h50], "R9", "aborted byte not stored", d, exp_mem[8'h50]);

        // R9: STOP in the middle of a pointer byte
        bus_start();
        send_byte({7'h2C, 1'b0}, ack);
        send_bits(8'h77, 5);
        bus_stop();
        check(reg_addr == 8'h50, "R9", "pointer kept after STOP abort", reg_addr, 8'h50);

        // R9: STOP in the middle of a data byte
        bus_start();
        send_byte({7'h2C, 1'b0}, ack);
        send_byte(8'h60, ack);
        send_bits(8'hC3, 3);
        bus_stop();
        read_one(7'h2C, d);
        check(d == exp_mem[8'h60], "R9", "data byte abort leaves register", d, exp_mem[8'h60]);

        // R2: strap moved while running
        strap = 2'b00;
        wait_q(2);
        probe_ack(7'h2C, 1'b1, "R2");
        probe_ack(7'h2E, 1'b0, "R2");

        // R1: every strap level decoded at reset
        do_reset(2'b00);
        probe_ack(7'h2E, 1'b1, "R1");
        probe_ack(7'h2C, 1'b0, "R1");
        do_reset(2'b10);
        probe_ack(7'h2D, 1'b1, "R1");
        probe_ack(7'h2E, 1'b0, "R1");
        do_reset(2'b11);
        probe_ack(7'h2C, 1'b1, "R1");
        check(reg_addr == 8'h00, "R10", "pointer cleared by reset", reg_addr, 0);

        wait_q(2);
        check(wq.size() == 0, "R5", "pending expected writes", wq.size(), 0);

        $display("CHECKS %0d ERRORS %0d", checks, errors);
        $finish;
    end

endmodule